// File: doc/BRIEF.md
# External Interrupt Edge Capture Unit

This block receives two asynchronous external interrupt pins, one feeding a non-maskable request and one feeding a critical request, and turns edges on them into sticky request lines that go straight to the processor core. Nothing sits between this block and the core: no general interrupt controller and no priority logic. Each pin passes through a synchroniser. The pin then goes through an edge detector whose sensitivity is set through a small configuration write port.

Software picks rising, falling or both edges for each source. The first write of a non-zero mode to a source freezes that source's setting until the next reset. A detected edge latches a pending flag. The flag stays set until the core returns a single-cycle acknowledge. The core can hold off the critical request with a mask input. The non-maskable request ignores that mask completely.

Top module: `ext_irq_edge_unit`

## Requirements
- R1: After reset both requests are low. Both sources are in mode 00 (no detection), so pin activity raises no request until a mode is written.
- R2: With mode 01 a source detects a 0-to-1 pin transition. The request rises at the third rising clock edge that samples the new pin level, counting the first such edge as number one.
- R3: With mode 10 a source detects only 1-to-0 transitions. A 0-to-1 transition on that source raises no request.
- R4: With mode 11 a source detects transitions in both directions.
- R5: A configuration write carries a source select, where 0 is the non-maskable source and 1 is the critical source, and a 2-bit mode. The first write of a non-zero mode to a source locks it. Later writes to that source have no effect. Only reset clears the lock and returns the mode to 00.
- R6: Writing mode 00 to an unlocked source does not lock it, so a later non-zero write is still accepted.
- R7: A pending request stays high until an acknowledge pulse for its source. It is low in the cycle after the acknowledge edge.
- R8: If a detected edge and an acknowledge for the same source meet at the same clock edge, the request stays high.
- R9: The critical mask has no effect on the non-maskable request.
- R10: While the critical mask is high, the critical request output is low, but a pending critical event stays latched. The event appears on the output as soon as the mask drops.
- R11: The two sources are independent: an acknowledge or a configuration write for one source leaves the other source's request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinNmi | input | 1 | Asynchronous non-maskable interrupt pin |
| pinCrit | input | 1 | Asynchronous critical interrupt pin |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | Source select for the write (0 non-maskable, 1 critical) |
| cfgEdge | input | 2 | Edge mode: 00 off, 01 rising, 10 falling, 11 both |
| critMask | input | 1 | Core-side block for the critical request |
| nmiAck | input | 1 | Acknowledge pulse for the non-maskable request |
| critAck | input | 1 | Acknowledge pulse for the critical request |
| nmiReq | output | 1 | Non-maskable request to the core |
| critReq | output | 1 | Critical request to the core |

## Verification
Directed sequences apply a rising edge to a falling-only source and a falling edge to a rising-only source. This shows that each mode selects direction rather than just any activity. A rewrite attempt after locking, and a mode-00 write before locking, show that only non-zero writes lock. Other directed cases place an acknowledge on the same clock edge as a new edge, and keep a critical event under mask while the non-maskable source fires. These show that a coincident event is not lost and that masking reaches only one source. A long random phase with both-edge modes varies pin toggles, acknowledges and mask changes, and compares every cycle against a bench model built from the requirements.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeMode_e;

  // per-source detector enables handed from control to datapath
  typedef struct packed {
    logic riseEn;
    logic fallEn;
  } edgeStrobe_t;

  localparam int SRC_NMI  = 0;
  localparam int SRC_CRIT = 1;

endpackage

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
  import irq_edge_pkg::*;
#(
  parameter int NUM_SRC = 2,
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWrEn,
  input  logic [SEL_W-1:0]              cfgSel,
  input  logic [1:0]                    cfgEdge,
  output edgeStrobe_t [NUM_SRC-1:0]     strobes,
  output logic [NUM_SRC-1:0]            lockVec,
  output logic [NUM_SRC-1:0][1:0]       cfgVec
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    edgeMode_e modeQ;
    logic      lockQ;
    logic      wrHit;

    assign wrHit = cfgWrEn && (cfgSel == SEL_W'(g)) && !lockQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeQ <= EDGE_OFF;
        lockQ <= 1'b0;
      end else if (wrHit) begin
        modeQ <= edgeMode_e'(cfgEdge);
        if (cfgEdge != 2'b00) lockQ <= 1'b1;
      end
    end

    assign strobes[g].riseEn = (modeQ == EDGE_RISE) || (modeQ == EDGE_BOTH);
    assign strobes[g].fallEn = (modeQ == EDGE_FALL) || (modeQ == EDGE_BOTH);
    assign lockVec[g]        = lockQ;
    assign cfgVec[g]         = modeQ;
  end

endmodule

// File: rtl/irq_edge_datapath.sv
module irq_edge_datapath
  import irq_edge_pkg::*;
#(
  parameter int                NUM_SRC     = 2,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NUM_SRC-1:0] MASKABLE   = 2'b10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        pinVec,
  input  edgeStrobe_t [NUM_SRC-1:0] strobes,
  input  logic [NUM_SRC-1:0]        ackVec,
  input  logic [NUM_SRC-1:0]        maskVec,
  output logic [NUM_SRC-1:0]        pendVec,
  output logic [NUM_SRC-1:0]        reqVec
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   prevQ;
    logic                   pendQ;
    logic                   syncOut;
    logic                   edgeHit;

    assign syncOut = syncQ[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '0;
        prevQ <= 1'b0;
        pendQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], pinVec[g]};
        prevQ <= syncOut;
        pendQ <= edgeHit | (pendQ & ~ackVec[g]);
      end
    end

    assign edgeHit = (strobes[g].riseEn &  syncOut & ~prevQ)
                   | (strobes[g].fallEn & ~syncOut &  prevQ);
    assign pendVec[g] = pendQ;

    if (MASKABLE[g]) begin : gMasked
      assign reqVec[g] = pendQ & ~maskVec[g];
    end else begin : gOpen
      logic unusedMask;
      assign unusedMask = maskVec[g];
      assign reqVec[g]  = pendQ;
    end
  end

endmodule

// File: rtl/ext_irq_edge_unit.sv
module ext_irq_edge_unit
  import irq_edge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinNmi,
  input  logic       pinCrit,
  input  logic       cfgWrEn,
  input  logic       cfgSel,
  input  logic [1:0] cfgEdge,
  input  logic       critMask,
  input  logic       nmiAck,
  input  logic       critAck,
  output logic       nmiReq,
  output logic       critReq
);

  localparam int NUM_SRC = 2;

  edgeStrobe_t [NUM_SRC-1:0] strobes;
  logic [NUM_SRC-1:0]        lockVec;
  logic [NUM_SRC-1:0][1:0]   cfgVec;
  logic [NUM_SRC-1:0]        pendVec;
  logic [NUM_SRC-1:0]        reqVec;
  logic [NUM_SRC-1:0]        pinVec;
  logic [NUM_SRC-1:0]        ackVec;
  logic [NUM_SRC-1:0]        maskVec;

  assign pinVec[SRC_NMI]   = pinNmi;
  assign pinVec[SRC_CRIT]  = pinCrit;
  assign ackVec[SRC_NMI]   = nmiAck;
  assign ackVec[SRC_CRIT]  = critAck;
  assign maskVec[SRC_NMI]  = 1'b0;
  assign maskVec[SRC_CRIT] = critMask;

  irq_edge_ctrl #(.NUM_SRC(NUM_SRC)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWrEn (cfgWrEn),
    .cfgSel  (cfgSel),
    .cfgEdge (cfgEdge),
    .strobes (strobes),
    .lockVec (lockVec),
    .cfgVec  (cfgVec)
  );

  irq_edge_datapath #(
    .NUM_SRC     (NUM_SRC),
    .SYNC_STAGES (SYNC_STAGES),
    .MASKABLE    (2'b10)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinVec  (pinVec),
    .strobes (strobes),
    .ackVec  (ackVec),
    .maskVec (maskVec),
    .pendVec (pendVec),
    .reqVec  (reqVec)
  );

  assign nmiReq  = reqVec[SRC_NMI];
  assign critReq = reqVec[SRC_CRIT];

endmodule

// File: rtl/irq_edge_checker.sv
module irq_edge_checker (
  input logic       clk,
  input logic       rstN,
  input logic       critMask,
  input logic       nmiAck,
  input logic       critAck,
  input logic       nmiReq,
  input logic       critReq,
  input logic [1:0] lockVec,
  input logic [1:0] pendVec,
  input logic [3:0] cfgFlat
);

  // R7: a raised non-maskable request holds until acknowledged
  a_r7_nmi_sticky: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq && !nmiAck |=> nmiReq);

  // R9: a pending non-maskable event always reaches the core
  a_r9_nmi_unmasked: assert property (@(posedge clk) disable iff (!rstN)
    pendVec[0] |-> nmiReq);

  // R10: mask blocks the critical output
  a_r10_crit_blocked: assert property (@(posedge clk) disable iff (!rstN)
    critMask |-> !critReq);

  // R10: masked critical event stays latched
  a_r10_pend_held: assert property (@(posedge clk) disable iff (!rstN)
    pendVec[1] && critMask && !critAck |=> pendVec[1]);

  // R11: acknowledging one source leaves the other pending
  a_r11_ack_isolated: assert property (@(posedge clk) disable iff (!rstN)
    nmiAck && !critAck && pendVec[1] |=> pendVec[1]);

  // R5: lock and mode frozen once set
  a_r5_nmi_lock_stays: assert property (@(posedge clk) disable iff (!rstN)
    lockVec[0] |=> lockVec[0] && $stable(cfgFlat[1:0]));

  a_r5_crit_lock_stays: assert property (@(posedge clk) disable iff (!rstN)
    lockVec[1] |=> lockVec[1] && $stable(cfgFlat[3:2]));

endmodule

bind ext_irq_edge_unit irq_edge_checker i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .critMask (critMask),
  .nmiAck   (nmiAck),
  .critAck  (critAck),
  .nmiReq   (nmiReq),
  .critReq  (critReq),
  .lockVec  (lockVec),
  .pendVec  (pendVec),
  .cfgFlat  (cfgVec)
);

// File: tb/test_ext_irq_edge_unit.sv
module test_ext_irq_edge_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pinNmi = 1'b0, pinCrit = 1'b0;
  logic       cfgWrEn = 1'b0, cfgSel = 1'b0;
  logic [1:0] cfgEdge = 2'b00;
  logic       critMask = 1'b0, nmiAck = 1'b0, critAck = 1'b0;
  logic       nmiReq, critReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string curReq = "R1";

  // bench model state, built from the requirements
  logic [1:0] mCfg [2];
  logic       mLock [2];
  logic       mPend [2];
  logic [1:0] d1, d2, d3;

  always #5 clk = ~clk;

  ext_irq_edge_unit i_ext_irq_edge_unit (
    .clk(clk), .rstN(rstN), .pinNmi(pinNmi), .pinCrit(pinCrit),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgEdge(cfgEdge),
    .critMask(critMask), .nmiAck(nmiAck), .critAck(critAck),
    .nmiReq(nmiReq), .critReq(critReq)
  );

  function automatic logic edgeSeen(logic cur, logic old, logic [1:0] mode);
    return (mode[0] & cur & ~old) | (mode[1] & ~cur & old);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 2; i++) begin
      mCfg[i] = 2'b00; mLock[i] = 1'b0; mPend[i] = 1'b0;
    end
    d1 = '0; d2 = '0; d3 = '0;
  endtask

  // one clock: model update at the edge, output check on the falling edge
  task automatic step();
    logic [1:0] ackV;
    @(posedge clk);
    ackV = {critAck, nmiAck};
    if (!rstN) begin
      modelReset();
    end else begin
      for (int i = 0; i < 2; i++) begin
        mPend[i] = edgeSeen(d2[i], d3[i], mCfg[i]) | (mPend[i] & ~ackV[i]);
        if (cfgWrEn && (int'(cfgSel) == i) && !mLock[i]) begin
          mCfg[i] = cfgEdge;
          if (cfgEdge != 2'b00) mLock[i] = 1'b1;
        end
      end
      d3 = d2; d2 = d1; d1 = {pinCrit, pinNmi};
    end
    @(negedge clk);
    check(curReq, nmiReq, mPend[0]);
    check(curReq, critReq, mPend[1] & ~critMask);
  endtask

  task automatic steps(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic writeCfg(logic sel, logic [1:0] mode);
    cfgWrEn = 1'b1; cfgSel = sel; cfgEdge = mode;
    step();
    cfgWrEn = 1'b0;
  endtask

  task automatic doReset();
    pinNmi = 1'b0; pinCrit = 1'b0; nmiAck = 1'b0; critAck = 1'b0; critMask = 1'b0;
    rstN = 1'b0;
    steps(2);
    rstN = 1'b1;
    step();
  endtask

  initial begin
    modelReset();
    void'($urandom(32'h1A2B3C4D));
    @(negedge clk);

    // R1: reset state and no detection in mode 00
    curReq = "R1";
    doReset();
    check("R1", nmiReq, 1'b0);
    check("R1", critReq, 1'b0);
    pinNmi = 1'b1; pinCrit = 1'b1; steps(4);
    pinNmi = 1'b0; pinCrit = 1'b0; steps(4);
    check("R1", nmiReq, 1'b0);

    // R6: mode 00 write keeps the source unlocked
    curReq = "R6";
    writeCfg(1'b0, 2'b00);
    writeCfg(1'b0, 2'b01);

    // R2: rising edge, third sampling edge
    curReq = "R2";
    pinNmi = 1'b1;
    steps(2);
    check("R2", nmiReq, 1'b0);
    step();
    check("R2", nmiReq, 1'b1);
    check("R6", nmiReq, 1'b1);

    // R7: sticky until acknowledge
    curReq = "R7";
    steps(3);
    check("R7", nmiReq, 1'b1);
    nmiAck = 1'b1; step(); nmiAck = 1'b0;
    check("R7", nmiReq, 1'b0);

    // R5: locked source ignores a rewrite to falling
    curReq = "R5";
    writeCfg(1'b0, 2'b10);
    pinNmi = 1'b0; steps(5);
    check("R5", nmiReq, 1'b0);

    // R3: falling-only on the critical source
    curReq = "R3";
    writeCfg(1'b1, 2'b10);
    pinCrit = 1'b1; steps(5);
    check("R3", critReq, 1'b0);
    pinCrit = 1'b0; steps(4);
    check("R3", critReq, 1'b1);

    // R10 / R9: mask blocks critical only
    curReq = "R10";
    critMask = 1'b1; step();
    check("R10", critReq, 1'b0);
    curReq = "R9";
    pinNmi = 1'b1; steps(4);
    check("R9", nmiReq, 1'b1);
    curReq = "R10";
    steps(3);
    critMask = 1'b0; step();
    check("R10", critReq, 1'b1);

    // R11: ack and write on one source leave the other alone
    curReq = "R11";
    nmiAck = 1'b1; step(); nmiAck = 1'b0;
    check("R11", critReq, 1'b1);
    check("R11", nmiReq, 1'b0);
    writeCfg(1'b0, 2'b11);
    check("R11", critReq, 1'b1);

    // R8: edge meeting acknowledge keeps the flag
    curReq = "R8";
    pinCrit = 1'b1; steps(3);
    pinCrit = 1'b0; step();
    step();
    critAck = 1'b1; step(); critAck = 1'b0;
    check("R8", critReq, 1'b1);
    critAck = 1'b1; step(); critAck = 1'b0;
    check("R8", critReq, 1'b0);

    // R5: reset clears the lock, new mode accepted
    curReq = "R5";
    doReset();
    writeCfg(1'b0, 2'b11);
    writeCfg(1'b1, 2'b11);
    pinNmi = 1'b1; steps(4);
    check("R5", nmiReq, 1'b1);
    nmiAck = 1'b1; step(); nmiAck = 1'b0;
    pinNmi = 1'b0; steps(4);
    check("R4", nmiReq, 1'b1);

    // R4: random stress with both-edge modes
    curReq = "R4";
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 5) == 0) pinNmi  = ~pinNmi;
      if ($urandom_range(0, 5) == 0) pinCrit = ~pinCrit;
      nmiAck  = ($urandom_range(0, 3) == 0);
      critAck = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 7) == 0) critMask = ~critMask;
      step();
    end
    nmiAck = 1'b0; critAck = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule